// File: doc/BRIEF.md
# Tearing-Effect Sync Detector

This block watches the single tearing-effect line coming back from a display panel and works out, from the length of each pulse, whether the panel has just reported a vertical sync or a horizontal sync. Pulse length is measured in ticks. A tick is one cycle of a divided clock, and the divider is programmable from 1 to 8 system clocks. A pulse that is too short to be either kind of sync is thrown away. Horizontal syncs and vertical syncs each have their own width threshold and their own polarity inversion bit.

When the selected condition occurs, the block drives an active-low match strobe for one clock. The falling edge of that strobe tells the host that a pending frame transfer can start. There are two matching modes:
- In vertical-only mode, every vertical sync produces a match.
- In line mode, a line counter is cleared by each vertical sync and advanced by each horizontal sync. A match is produced when the counter reaches a programmed target line.

The controller is a three-state machine:
- `ST_OFF`: detection disabled.
- `ST_WAIT_VS`: waiting for a vertical sync.
- `ST_COUNT`: counting lines in line mode.

Its transitions are:
- enable (`ST_OFF` to `ST_WAIT_VS`)
- frame start (`ST_WAIT_VS` to `ST_COUNT` on a vertical sync in line mode)
- mode leave (`ST_COUNT` to `ST_WAIT_VS` when the mode is no longer line mode)
- disable (any state to `ST_OFF`)

Top module: `te_sync_detector`

## Requirements
- R1: While `det_enable` is low, or `sync_mode[1]` is 0 (modes 0 and 1), `match_n` stays high, `hsync_det` and `vsync_det` stay low, and `line_no` reads 0.
- R2: Pulse width is counted in ticks of `clk_div`+1 clocks each (`clk_div` 0..7). A pulse lasting N clocks with `clk_div`=3 measures N/4 ticks when N is a multiple of 4.
- R3: An active pulse shorter than `hs_width`+1 ticks produces no detection and no match.
- R4: An active pulse of at least `hs_width`+1 ticks but fewer than (`vs_width`+1)*8 ticks pulses `hsync_det` high for one clock.
- R5: An active pulse of at least (`vs_width`+1)*8 ticks pulses `vsync_det` high for one clock. Legal `vs_width` values are 0..510.
- R6: The active level is high for the horizontal view when `hs_inv`=0 and low when `hs_inv`=1. The vertical view follows `vs_inv` in the same way.
- R7: With `sync_mode`=3 (binary 11), every vertical sync produces one match and horizontal syncs produce none.
- R8: With `sync_mode`=2 (binary 10), a vertical sync clears `line_no` and each horizontal sync increments it. A match fires when the incremented value equals `target_line`, or on the vertical sync itself when `target_line` is 0.
- R9: The match strobe is `match_n` low for exactly one clock. It is low in the fourth clock after the clock in which the ending edge of the sync pulse is applied at `te_in`. `hsync_det`/`vsync_det` rise one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| te_in | input | 1 | Tearing-effect line from the panel (asynchronous) |
| det_enable | input | 1 | Master enable of the detection logic |
| sync_mode | input | 2 | 0/1 off, 2 line mode, 3 vertical-only mode |
| clk_div | input | 3 | Tick divider minus one |
| hs_width | input | 3 | Horizontal threshold in ticks minus one |
| vs_width | input | 9 | Vertical threshold in units of 8 ticks, minus one |
| hs_inv | input | 1 | Invert horizontal active level |
| vs_inv | input | 1 | Invert vertical active level |
| target_line | input | 11 | Line number that triggers a match in line mode |
| match_n | output | 1 | Active-low one-clock match strobe |
| hsync_det | output | 1 | One-clock pulse per detected horizontal sync |
| vsync_det | output | 1 | One-clock pulse per detected vertical sync |
| line_no | output | 11 | Current line count |

## Verification
The assertions assume that the divider, the thresholds and both inversion bits are held steady while detection is enabled. They also assume a legal vertical threshold that is larger than the horizontal one, and sync pulses separated by several idle clocks. The stimulus respects this: every configuration change is made with `det_enable` low, the inversion bits are changed only while the line sits at its idle level, and each pulse is followed by at least ten idle clocks. Pulse lengths sit right at each threshold and one tick on either side of it.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;
    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_WAIT_VS = 2'd1,
        ST_COUNT   = 2'd2
    } te_state_e;

    localparam logic [1:0] MODE_LINE  = 2'b10;
    localparam logic [1:0] MODE_VSYNC = 2'b11;
endpackage

// File: rtl/te_tick_gen.sv
module te_tick_gen #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;

    assign tick = en && (phase_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!en || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/te_pulse_classifier.sv
module te_pulse_classifier #(
    parameter int HS_W = 3,
    parameter int VS_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            te_in,
    input  logic            tick,
    input  logic            hs_inv,
    input  logic            vs_inv,
    input  logic [HS_W-1:0] hs_width,
    input  logic [VS_W-1:0] vs_width,
    output logic            hs_evt,
    output logic            vs_evt
);
    localparam int CNT_W = VS_W + 4;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] hs_thr, vs_thr;
    assign hs_thr = CNT_W'(hs_width) + CNT_W'(1);
    assign vs_thr = (CNT_W'(vs_width) + CNT_W'(1)) << 3;

    // two-flop synchronizer plus one history stage for edge finding
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= te_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // view 0 sees the line with horizontal polarity, view 1 with vertical
    logic [1:0] inv, act, act_d, ends;
    assign inv = {vs_inv, hs_inv};

    for (genvar v = 0; v < 2; v++) begin : g_view
        logic [CNT_W-1:0] wid;
        assign act[v]   = s2 ^ inv[v];
        assign act_d[v] = s3 ^ inv[v];
        assign ends[v]  = en && act_d[v] && !act[v];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wid <= '0;
            end else if (!en || !act[v]) begin
                wid <= '0;
            end else if (tick && (wid != CNT_MAX)) begin
                wid <= wid + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_evt <= 1'b0;
            vs_evt <= 1'b0;
        end else begin
            hs_evt <= ends[0] && (g_view[0].wid >= hs_thr) && (g_view[0].wid < vs_thr);
            vs_evt <= ends[1] && (g_view[1].wid >= vs_thr);
        end
    end

    a_r4_hs_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        hs_evt |=> !hs_evt);
    a_r5_vs_evt_single: assert property (@(posedge clk) disable iff (!rst_n)
        vs_evt |=> !vs_evt);
    a_r1_no_evt_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!hs_evt && !vs_evt));
endmodule

// File: rtl/te_match_fsm.sv
module te_match_fsm
    import te_sync_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [LINE_W-1:0] target,
    input  logic              hs_evt,
    input  logic              vs_evt,
    output logic              match_n,
    output logic [LINE_W-1:0] line_no
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    te_state_e         state_q, state_d;
    logic [LINE_W-1:0] lc_q, lc_d;
    logic              fire;

    always_comb begin
        state_d = state_q;
        lc_d    = lc_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                state_d = ST_WAIT_VS;
            end
            ST_WAIT_VS: begin
                if (vs_evt) begin
                    if (mode == MODE_LINE) begin
                        state_d = ST_COUNT;
                        lc_d    = '0;
                        fire    = (target == '0);
                    end else begin
                        fire = 1'b1;
                    end
                end
            end
            ST_COUNT: begin
                if (mode != MODE_LINE) begin
                    state_d = ST_WAIT_VS;
                end else if (vs_evt) begin
                    lc_d = '0;
                    fire = (target == '0);
                end else if (hs_evt && (lc_q != LINE_MAX)) begin
                    lc_d = lc_q + LINE_W'(1);
                    fire = ((lc_q + LINE_W'(1)) == target);
                end
            end
            default: state_d = ST_OFF;
        endcase
        if (!en) begin
            state_d = ST_OFF;
            lc_d    = '0;
            fire    = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            lc_q    <= '0;
        end else begin
            state_q <= state_d;
            lc_q    <= lc_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            match_n <= 1'b1;
        end else begin
            match_n <= !fire;
        end
    end

    assign line_no = lc_q;

    a_r9_match_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !match_n |=> match_n);
    a_r7_match_needs_vsync: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_n && ($past(mode) == MODE_VSYNC)) |-> $past(vs_evt));
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (match_n && (line_no == '0)));
    a_r8_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_COUNT) && ($past(state_q) == ST_COUNT) && (lc_q != $past(lc_q)))
        |-> (($past(vs_evt) && (lc_q == '0)) ||
             ($past(hs_evt) && (lc_q == $past(lc_q) + LINE_W'(1)))));
endmodule

// File: rtl/te_sync_detector.sv
module te_sync_detector #(
    parameter int DIV_W  = 3,
    parameter int HS_W   = 3,
    parameter int VS_W   = 9,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te_in,
    input  logic              det_enable,
    input  logic [1:0]        sync_mode,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [HS_W-1:0]   hs_width,
    input  logic [VS_W-1:0]   vs_width,
    input  logic              hs_inv,
    input  logic              vs_inv,
    input  logic [LINE_W-1:0] target_line,
    output logic              match_n,
    output logic              hsync_det,
    output logic              vsync_det,
    output logic [LINE_W-1:0] line_no
);
    logic en, tick;

    assign en = det_enable && sync_mode[1];

    te_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .div  (clk_div),
        .tick (tick)
    );

    te_pulse_classifier #(.HS_W(HS_W), .VS_W(VS_W)) u_class (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .te_in   (te_in),
        .tick    (tick),
        .hs_inv  (hs_inv),
        .vs_inv  (vs_inv),
        .hs_width(hs_width),
        .vs_width(vs_width),
        .hs_evt  (hsync_det),
        .vs_evt  (vsync_det)
    );

    te_match_fsm #(.LINE_W(LINE_W)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .mode   (sync_mode),
        .target (target_line),
        .hs_evt (hsync_det),
        .vs_evt (vsync_det),
        .match_n(match_n),
        .line_no(line_no)
    );
endmodule

// File: tb/te_sync_detector_tb.sv
module te_sync_detector_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        te_in = 1'b0;
    logic        det_enable = 1'b0;
    logic [1:0]  sync_mode = 2'd0;
    logic [2:0]  clk_div = 3'd0;
    logic [2:0]  hs_width = 3'd1;
    logic [8:0]  vs_width = 9'd0;
    logic        hs_inv = 1'b0;
    logic        vs_inv = 1'b0;
    logic [10:0] target_line = 11'd0;
    logic        match_n, hsync_det, vsync_det;
    logic [10:0] line_no;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    te_sync_detector u_dut (
        .clk(clk), .rst_n(rst_n), .te_in(te_in), .det_enable(det_enable),
        .sync_mode(sync_mode), .clk_div(clk_div), .hs_width(hs_width),
        .vs_width(vs_width), .hs_inv(hs_inv), .vs_inv(vs_inv),
        .target_line(target_line), .match_n(match_n), .hsync_det(hsync_det),
        .vsync_det(vsync_det), .line_no(line_no)
    );

    // behavioural reference, integer based
    bit m_q1, m_q2, m_q3, m_he, m_ve, m_match_n;
    int m_ph, m_wh, m_wv, m_st, m_lc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q1 = 0; m_q2 = 0; m_q3 = 0; m_he = 0; m_ve = 0; m_match_n = 1;
            m_ph = 0; m_wh = 0; m_wv = 0; m_st = 0; m_lc = 0;
        end else begin
            bit en, ah, av, pah, pav, tk, f, nhe, nve;
            int hthr, vthr, nst, nlc;
            en   = det_enable && sync_mode[1];
            ah   = m_q2 ^ hs_inv;  av  = m_q2 ^ vs_inv;
            pah  = m_q3 ^ hs_inv;  pav = m_q3 ^ vs_inv;
            tk   = en && (m_ph == int'(clk_div));
            hthr = int'(hs_width) + 1;
            vthr = (int'(vs_width) + 1) * 8;
            nhe  = en && pah && !ah && m_wh >= hthr && m_wh < vthr;
            nve  = en && pav && !av && m_wv >= vthr;
            nst = m_st; nlc = m_lc; f = 0;
            if (!en) begin
                nst = 0; nlc = 0;
            end else if (m_st == 0) begin
                nst = 1;
            end else if (m_st == 1) begin
                if (m_ve) begin
                    if (sync_mode == 2'd2) begin nst = 2; nlc = 0; f = (target_line == 0); end
                    else f = 1;
                end
            end else begin
                if (sync_mode != 2'd2) nst = 1;
                else if (m_ve) begin nlc = 0; f = (target_line == 0); end
                else if (m_he && m_lc < 2047) begin
                    nlc = m_lc + 1; f = (nlc == int'(target_line));
                end
            end
            m_wh = (!en || !ah) ? 0 : ((tk && m_wh < 8191) ? m_wh + 1 : m_wh);
            m_wv = (!en || !av) ? 0 : ((tk && m_wv < 8191) ? m_wv + 1 : m_wv);
            m_ph = (!en || tk) ? 0 : m_ph + 1;
            m_q3 = m_q2; m_q2 = m_q1; m_q1 = te_in;
            m_he = nhe; m_ve = nve; m_st = nst; m_lc = nlc; m_match_n = !f;
        end
    end

    // event counters seen at the ports
    int c_h = 0, c_v = 0, c_m = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_checks++;
            if (match_n !== m_match_n || hsync_det !== m_he || vsync_det !== m_ve
                || line_no !== m_lc[10:0]) begin
                n_fail++;
                $display("FAIL %s model: actual m=%b h=%b v=%b ln=%0d expected m=%b h=%b v=%b ln=%0d",
                         cur_req, match_n, hsync_det, vsync_det, line_no,
                         m_match_n, m_he, m_ve, m_lc);
            end
            if (hsync_det) c_h++;
            if (vsync_det) c_v++;
            if (!match_n) c_m++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input bit act_lvl, input int len);
        @(negedge clk); te_in = act_lvl;
        repeat (len - 1) @(negedge clk);
        @(negedge clk); te_in = !act_lvl;
        idle(12);
    endtask

    task automatic counts(input string req, input int h0, input int v0, input int m0,
                          input int eh, input int ev, input int em);
        check((c_h - h0) == eh, {req, " hsync count"}, c_h - h0, eh);
        check((c_v - v0) == ev, {req, " vsync count"}, c_v - v0, ev);
        check((c_m - m0) == em, {req, " match count"}, c_m - m0, em);
    endtask

    initial begin
        int h0, v0, m0;
        repeat (3) @(negedge clk);
        check(match_n == 1'b1, "R1 reset match_n", match_n, 1);
        check(line_no == 0, "R1 reset line_no", line_no, 0);
        rst_n = 1'b1;
        idle(4);

        // R1: disabled master enable, then mode 1
        cur_req = "R1";
        h0 = c_h; v0 = c_v; m0 = c_m;
        sync_mode = 2'd3; det_enable = 1'b0;
        pulse(1, 4); pulse(1, 12);
        sync_mode = 2'd1; det_enable = 1'b1;
        pulse(1, 4); pulse(1, 12);
        counts("R1", h0, v0, m0, 0, 0, 0);

        // R3 R4 R5 R7: thresholds 2 and 8 ticks, divider 1
        det_enable = 1'b0; sync_mode = 2'd3; idle(2);
        det_enable = 1'b1; idle(3);
        cur_req = "R3";
        h0 = c_h; v0 = c_v; m0 = c_m;
        pulse(1, 1);
        counts("R3 glitch", h0, v0, m0, 0, 0, 0);
        cur_req = "R4";
        h0 = c_h; v0 = c_v; m0 = c_m;
        pulse(1, 2); pulse(1, 4); pulse(1, 7);
        counts("R4 hsync band", h0, v0, m0, 3, 0, 0);
        cur_req = "R5";
        h0 = c_h; v0 = c_v; m0 = c_m;
        pulse(1, 8); pulse(1, 12);
        counts("R5 R7 vsync", h0, v0, m0, 0, 2, 2);

        // R9: latency and width of the match strobe
        cur_req = "R9";
        @(negedge clk); te_in = 1'b1;
        repeat (11) @(negedge clk);
        te_in = 1'b0;
        repeat (2) @(negedge clk);
        check(vsync_det == 1'b0, "R9 vsync not yet", vsync_det, 0);
        @(negedge clk);
        check(vsync_det == 1'b1, "R9 vsync third clock", vsync_det, 1);
        check(match_n == 1'b1, "R9 match not yet", match_n, 1);
        @(negedge clk);
        check(match_n == 1'b0, "R9 match fourth clock", match_n, 0);
        @(negedge clk);
        check(match_n == 1'b1, "R9 match one clock", match_n, 1);
        idle(10);

        // R2: divider of 4 clocks per tick
        cur_req = "R2";
        det_enable = 1'b0; clk_div = 3'd3; idle(2);
        det_enable = 1'b1; idle(3);
        h0 = c_h; v0 = c_v; m0 = c_m;
        pulse(1, 4);    // 1 tick: glitch
        pulse(1, 12);   // 3 ticks: horizontal
        pulse(1, 28);   // 7 ticks: horizontal
        pulse(1, 40);   // 10 ticks: vertical
        counts("R2 divided ticks", h0, v0, m0, 2, 1, 1);

        // R8: line mode, target 3
        cur_req = "R8";
        det_enable = 1'b0; clk_div = 3'd0; sync_mode = 2'd2; target_line = 11'd3; idle(2);
        det_enable = 1'b1; idle(3);
        h0 = c_h; v0 = c_v; m0 = c_m;
        pulse(1, 4);    // horizontal before any vertical: no count
        check(line_no == 0, "R8 no count before frame", line_no, 0);
        pulse(1, 12);
        for (int i = 0; i < 5; i++) pulse(1, 4);
        check(line_no == 5, "R8 line count", line_no, 5);
        counts("R8 target 3", h0, v0, m0, 6, 1, 1);
        pulse(1, 12);
        check(line_no == 0, "R8 vsync clears line", line_no, 0);
        h0 = c_h; v0 = c_v; m0 = c_m;
        target_line = 11'd0;
        pulse(1, 12); pulse(1, 4);
        counts("R8 target 0", h0, v0, m0, 1, 1, 1);

        // R6: both views inverted, line idles high
        cur_req = "R6";
        det_enable = 1'b0; sync_mode = 2'd3; idle(1);
        te_in = 1'b1; hs_inv = 1'b1; vs_inv = 1'b1; idle(6);
        det_enable = 1'b1; idle(3);
        h0 = c_h; v0 = c_v; m0 = c_m;
        pulse(0, 4); pulse(0, 12);
        counts("R6 inverted", h0, v0, m0, 1, 1, 1);

        idle(5);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule